// File: doc/BRIEF.md
# Register Rename Map Table

The block holds the speculative mapping from architectural register numbers to physical register numbers for an out-of-order core, together with a second, architectural copy of the same mapping that retiring instructions update. A rename group of up to four instructions is served each cycle. Every instruction has three read ports: two sources and the old destination. Read addresses come straight from the instruction buffer in the decode cycle and are registered, so the physical numbers appear in the following cycle. Rename writes are not applied at once. They are captured in a register and written into storage one cycle later. A forwarding path places the captured write data on the read results of that next cycle, so the table never needs to stall.

When several lanes of one group write the same architectural register, the highest-numbered lane wins, both in storage and on the forwarding path. The same rule applies to commit writes into the architectural copy. On a redirect the speculative copy is loaded from the architectural copy, including any commits made in that cycle. Any captured rename writes and any rename writes offered in the redirect cycle are dropped. Architectural register 0 always maps to physical register 0.

Top module: `rmt_map_table`

## Requirements
- R1: After reset, both copies hold the identity mapping (entry i maps to physical i), and every read result is 0 in the first cycle after reset is released.
- R2: A read address presented in cycle t produces its physical number on the matching read-data port in cycle t+1, and on no other cycle.
- R3: A rename write (lane valid, architectural number, physical number) presented in cycle t is seen by reads whose addresses were presented in cycle t, and by all later reads.
- R4: A speculative mapping stays in place until a later rename write to the same entry or a redirect replaces it.
- R5: When several rename lanes in one cycle write the same entry, the highest lane index wins, for reads in the next cycle and for storage afterwards.
- R6: Commit writes update only the architectural copy. Reads of the speculative mapping do not see them until a redirect.
- R7: With redirect high in cycle t, reads whose addresses were presented in cycle t or later return the architectural mapping, including the commits of cycle t. Rename writes of cycle t and the still-pending writes of cycle t-1 are discarded.
- R8: Reads of architectural register 0 always return 0, and rename or commit writes to register 0 have no effect.
- R9: When several commit lanes in one cycle write the same entry, the highest lane index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_addr | input | 12x5 | Read addresses; port 3*i+j is operand j of instruction i |
| rd_data | output | 12x7 | Physical numbers, one cycle after the address |
| wr_valid | input | 4 | Rename write enable per lane |
| wr_arch | input | 4x5 | Rename write architectural number per lane |
| wr_preg | input | 4x7 | Rename write physical number per lane |
| cm_valid | input | 4 | Commit write enable per lane |
| cm_arch | input | 4x5 | Commit architectural number per lane |
| cm_preg | input | 4x7 | Commit physical number per lane |
| redirect | input | 1 | Restore the speculative copy from the architectural copy |

## Verification
The riskiest overlap is a read that meets a write still held in the capture register: the read address comes in during the same cycle as a rename write to the same entry. The writes are often several lanes aimed at one entry. The bench provokes this by squeezing random addresses into a narrow range, so that reads, rename lanes and commit lanes collide often. A second overlap is a redirect that arrives while a capture is pending and while commits are landing. It is also provoked by random pulses and by a directed case where all commit lanes hit one entry. In both cases every read port is judged each cycle against a behavioural model that applies writes in lane order at once, with no delay.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
  parameter int ARCH_REGS = 32;
  parameter int PHYS_W    = 7;
  parameter int GROUP     = 4;
  parameter int SRC_PER   = 3;
endpackage

// File: rtl/rmt_wr_latch.sv
module rmt_wr_latch #(
  parameter int GROUP = rmt_pkg::GROUP,
  parameter int AW    = 5,
  parameter int PW    = rmt_pkg::PHYS_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      flush,
  input  logic [GROUP-1:0]          in_valid,
  input  logic [GROUP-1:0][AW-1:0]  in_arch,
  input  logic [GROUP-1:0][PW-1:0]  in_preg,
  output logic [GROUP-1:0]          q_valid,
  output logic [GROUP-1:0][AW-1:0]  q_arch,
  output logic [GROUP-1:0][PW-1:0]  q_preg
);
  // a lane is kept only if it targets a real register and no flush drops it
  logic [GROUP-1:0] keep;
  always_comb begin
    for (int l = 0; l < GROUP; l++)
      keep[l] = in_valid[l] && (in_arch[l] != '0) && !flush;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= '0;
      q_arch  <= '0;
      q_preg  <= '0;
    end else begin
      q_valid <= keep;
      q_arch  <= in_arch;
      q_preg  <= in_preg;
    end
  end

  // R7: nothing stays pending after a redirect cycle
  p_flush_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (q_valid == '0));
  // R8: a write to register 0 is never latched
  p_zero_not_latched_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid[0] && in_arch[0] == '0) |=> !q_valid[0]);
endmodule

// File: rtl/rmt_read_port.sv
module rmt_read_port #(
  parameter int NUM   = rmt_pkg::ARCH_REGS,
  parameter int GROUP = rmt_pkg::GROUP,
  parameter int AW    = 5,
  parameter int PW    = rmt_pkg::PHYS_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [AW-1:0]             addr,
  input  logic [PW-1:0]             tab [NUM],
  input  logic [GROUP-1:0]          q_valid,
  input  logic [GROUP-1:0][AW-1:0]  q_arch,
  input  logic [GROUP-1:0][PW-1:0]  q_preg,
  output logic [PW-1:0]             data,
  output logic                      fwd_hit
);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr;
  end

  // later lanes override earlier ones: youngest write forwards
  always_comb begin
    data    = tab[addr_q];
    fwd_hit = 1'b0;
    for (int l = 0; l < GROUP; l++) begin
      if (q_valid[l] && q_arch[l] == addr_q) begin
        data    = q_preg[l];
        fwd_hit = 1'b1;
      end
    end
  end

  // R8: register 0 reads back physical 0
  p_zero_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(addr) == '0) |-> (data == '0));
  // R3: a forwarded result comes from the youngest matching pending lane
  p_fwd_last_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid[GROUP-1] && q_arch[GROUP-1] == addr_q) |-> (data == q_preg[GROUP-1]));
endmodule

// File: rtl/rmt_map_table.sv
module rmt_map_table #(
  parameter int NUM     = rmt_pkg::ARCH_REGS,
  parameter int PW      = rmt_pkg::PHYS_W,
  parameter int GROUP   = rmt_pkg::GROUP,
  parameter int SRC_PER = rmt_pkg::SRC_PER,
  localparam int AW     = $clog2(NUM),
  localparam int NRD    = GROUP * SRC_PER
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NRD-1:0][AW-1:0]    rd_addr,
  output logic [NRD-1:0][PW-1:0]    rd_data,
  input  logic [GROUP-1:0]          wr_valid,
  input  logic [GROUP-1:0][AW-1:0]  wr_arch,
  input  logic [GROUP-1:0][PW-1:0]  wr_preg,
  input  logic [GROUP-1:0]          cm_valid,
  input  logic [GROUP-1:0][AW-1:0]  cm_arch,
  input  logic [GROUP-1:0][PW-1:0]  cm_preg,
  input  logic                      redirect
);
  logic [PW-1:0] spec_tab  [NUM];
  logic [PW-1:0] arch_tab  [NUM];
  logic [PW-1:0] spec_next [NUM];
  logic [PW-1:0] arch_next [NUM];

  logic [GROUP-1:0]          q_valid;
  logic [GROUP-1:0][AW-1:0]  q_arch;
  logic [GROUP-1:0][PW-1:0]  q_preg;
  logic [NRD-1:0]            fwd_hit;
  logic                      tabs_equal;

  // identity mapping used at reset
  function automatic logic [PW-1:0] ident(input int i);
    return PW'(i);
  endfunction

  rmt_wr_latch #(.GROUP(GROUP), .AW(AW), .PW(PW)) u_latch (
    .clk(clk), .rst_n(rst_n), .flush(redirect),
    .in_valid(wr_valid), .in_arch(wr_arch), .in_preg(wr_preg),
    .q_valid(q_valid), .q_arch(q_arch), .q_preg(q_preg)
  );

  // commits first, lane order: youngest wins
  always_comb begin
    arch_next = arch_tab;
    for (int l = 0; l < GROUP; l++)
      if (cm_valid[l] && cm_arch[l] != '0) arch_next[cm_arch[l]] = cm_preg[l];
  end

  always_comb begin
    if (redirect) begin
      spec_next = arch_next;
    end else begin
      spec_next = spec_tab;
      for (int l = 0; l < GROUP; l++)
        if (q_valid[l]) spec_next[q_arch[l]] = q_preg[l];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM; i++) begin
        spec_tab[i] <= ident(i);
        arch_tab[i] <= ident(i);
      end
    end else begin
      spec_tab <= spec_next;
      arch_tab <= arch_next;
    end
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      rmt_read_port #(.NUM(NUM), .GROUP(GROUP), .AW(AW), .PW(PW)) u_rd (
        .clk(clk), .rst_n(rst_n), .addr(rd_addr[p]), .tab(spec_tab),
        .q_valid(q_valid), .q_arch(q_arch), .q_preg(q_preg),
        .data(rd_data[p]), .fwd_hit(fwd_hit[p])
      );
    end
  endgenerate

  assign tabs_equal = (spec_tab == arch_tab);

  // R9: youngest commit lane lands in the architectural copy
  p_commit_youngest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_valid[GROUP-1] && cm_arch[GROUP-1] != '0)
      |=> (arch_tab[$past(cm_arch[GROUP-1])] == $past(cm_preg[GROUP-1])));
  // R5: youngest pending rename lane lands in the speculative copy
  p_spec_youngest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid[GROUP-1] && !redirect)
      |=> (spec_tab[$past(q_arch[GROUP-1])] == $past(q_preg[GROUP-1])));
  // R7: after a redirect both copies agree
  p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> tabs_equal);
  // R8: entry 0 never leaves physical 0
  p_entry0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (spec_tab[0] == '0) && (arch_tab[0] == '0));
endmodule

// File: tb/tb_rmt_map_table.sv
module tb_rmt_map_table;
  localparam int NUM = 32, PW = 7, G = 4, SP = 3, AW = 5, NRD = G * SP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NRD-1:0][AW-1:0] rd_addr = '0;
  logic [NRD-1:0][PW-1:0] rd_data;
  logic [G-1:0]           wr_valid = '0;
  logic [G-1:0][AW-1:0]   wr_arch = '0;
  logic [G-1:0][PW-1:0]   wr_preg = '0;
  logic [G-1:0]           cm_valid = '0;
  logic [G-1:0][AW-1:0]   cm_arch = '0;
  logic [G-1:0][PW-1:0]   cm_preg = '0;
  logic                   redirect = 1'b0;

  always #5 clk = ~clk;

  rmt_map_table dut (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_arch(wr_arch), .wr_preg(wr_preg),
    .cm_valid(cm_valid), .cm_arch(cm_arch), .cm_preg(cm_preg),
    .redirect(redirect)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  // behavioural model: writes take effect immediately, no latch
  int vis [NUM];
  int arch [NUM];
  bit touched [NUM];
  int exp_d [NRD];
  string tag [NRD];
  bit exp_ok = 0;

  task automatic check(input bit cond, input string req, input int act, input int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic compare_outputs();
    if (exp_ok)
      for (int p = 0; p < NRD; p++)
        check(rd_data[p] == PW'(exp_d[p]), tag[p], int'(rd_data[p]), exp_d[p]);
  endtask

  // apply the staged inputs to the model and compute next-cycle expectations
  task automatic model_step();
    int nw [NUM];
    int nc [NUM];
    for (int i = 0; i < NUM; i++) begin nw[i] = 0; nc[i] = 0; end
    for (int l = 0; l < G; l++)
      if (cm_valid[l] && cm_arch[l] != 0) begin
        arch[cm_arch[l]] = cm_preg[l];
        nc[cm_arch[l]]++;
      end
    if (redirect) begin
      for (int i = 0; i < NUM; i++) begin vis[i] = arch[i]; touched[i] = 1; end
    end else begin
      for (int l = 0; l < G; l++)
        if (wr_valid[l] && wr_arch[l] != 0) begin
          vis[wr_arch[l]] = wr_preg[l];
          nw[wr_arch[l]]++;
        end
    end
    for (int p = 0; p < NRD; p++) begin
      int a = rd_addr[p];
      exp_d[p] = (a == 0) ? 0 : vis[a];
      if (redirect)       tag[p] = (nc[a] > 1) ? "R9" : "R7";
      else if (a == 0)    tag[p] = "R8";
      else if (nw[a] > 1) tag[p] = "R5";
      else if (nw[a] == 1) tag[p] = "R3";
      else if (nc[a] > 0) tag[p] = "R6";
      else if (touched[a]) tag[p] = "R4";
      else                tag[p] = "R2";
    end
    for (int l = 0; l < G; l++)
      if (!redirect && wr_valid[l] && wr_arch[l] != 0) touched[wr_arch[l]] = 1;
    exp_ok = 1;
  endtask

  task automatic random_stim(input int arange, input int wpct, input int cpct, input int rpct);
    for (int p = 0; p < NRD; p++) rd_addr[p] = AW'($urandom_range(arange - 1));
    for (int l = 0; l < G; l++) begin
      wr_valid[l] = ($urandom_range(99) < wpct);
      wr_arch[l]  = AW'($urandom_range(arange - 1));
      wr_preg[l]  = PW'($urandom);
      cm_valid[l] = ($urandom_range(99) < cpct);
      cm_arch[l]  = AW'($urandom_range(arange - 1));
      cm_preg[l]  = PW'($urandom);
    end
    redirect = ($urandom_range(99) < rpct);
  endtask

  task automatic cycle();
    model_step();
    @(negedge clk);
    compare_outputs();
  endtask

  initial begin
    for (int i = 0; i < NUM; i++) begin vis[i] = i; arch[i] = i; touched[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: read results are 0 right after reset
    for (int p = 0; p < NRD; p++) check(rd_data[p] == '0, "R1", int'(rd_data[p]), 0);

    // R1/R2: identity reads, no writes
    for (int n = 0; n < 20; n++) begin
      random_stim(NUM, 0, 0, 0);
      for (int p = 0; p < NRD; p++) tag[p] = "R1";
      model_step();
      for (int p = 0; p < NRD; p++) if (rd_addr[p] != 0) tag[p] = "R1";
      @(negedge clk);
      compare_outputs();
    end

    // R5: all rename lanes hit one entry, reads of that entry in the same cycle
    for (int n = 0; n < 10; n++) begin
      random_stim(NUM, 100, 0, 0);
      for (int l = 0; l < G; l++) wr_arch[l] = AW'(5 + n);
      rd_addr[0] = AW'(5 + n);
      cycle();
    end

    // R8: writes to register 0
    for (int n = 0; n < 5; n++) begin
      random_stim(NUM, 100, 100, 0);
      for (int l = 0; l < G; l++) begin wr_arch[l] = '0; cm_arch[l] = '0; end
      rd_addr[1] = '0;
      cycle();
    end

    // R6 then R9/R7: commits hidden until redirect with all lanes on one entry
    random_stim(NUM, 0, 100, 0);
    for (int l = 0; l < G; l++) cm_arch[l] = AW'(3);
    rd_addr[2] = AW'(3);
    cycle();
    random_stim(NUM, 100, 100, 0);
    for (int l = 0; l < G; l++) cm_arch[l] = AW'(9);
    redirect = 1'b1;
    rd_addr[2] = AW'(9);
    rd_addr[3] = AW'(3);
    cycle();

    // mixed random traffic with heavy collisions, and a wide phase
    for (int n = 0; n < 1500; n++) begin
      random_stim(6, 60, 40, 6);
      cycle();
    end
    for (int n = 0; n < 1500; n++) begin
      random_stim(NUM, 50, 50, 3);
      cycle();
    end

    redirect = 1'b0;
    wr_valid = '0;
    cm_valid = '0;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule